// File: doc/BRIEF.md
# Monotonic Down-Only Counter Bank

This block keeps two 32-bit counters that can only ever move downward, plus a write-once lock register that can freeze either counter. A host reaches everything through one block port. The port has a byte address, a 32-bit data word, a write strobe and a read strobe. A counter lives at address 5 or address 6. A write to that address names the full new value. The block accepts it only if the value is strictly below what the counter holds now, so the host can step down by any amount. When a write is refused, the host sees a one-cycle reject pulse.

An accepted value does not land at once. It is held in a shadow register while a fixed-length programming sequence runs, with busy held high. The counter takes the shadow value only at the final edge of that sequence. A power-fail input raised during the sequence throws the pending value away and leaves the old contents untouched. A counter that has reached zero can never be raised again. Setting a counter's lock bit makes that counter read-only for good.

Top module: `mono_ctr_bank`

## Requirements
- R1: After reset, the counter at address 5 reads FFFF_FFFEh and the counter at address 6 reads FFFF_FFFFh. The lock register reads zero, and busy and reject are low.
- R2: A write to address 5 or 6 whose value is equal to or above the stored value changes nothing. It raises reject for exactly the one cycle after the write and does not raise busy.
- R3: A write to address 5 or 6 whose value is strictly below the stored value raises busy from the next cycle for exactly PROG_CYCLES cycles (default 8) and does not raise reject. The new value is readable once busy has fallen.
- R4: When pwr_fail is high during any busy cycle, including the last one, busy falls on the next cycle and the counter keeps its previous value.
- R5: Every write presented while busy is high is ignored: no reject, and no change to either counter or to the lock register.
- R6: A counter holding zero rejects all further writes and stays at zero.
- R7: A write to address 255 ORs wdata[0] into the lock bit of counter 5 and wdata[1] into the lock bit of counter 6. Lock bits are never cleared. A locked counter rejects every write and keeps its value.
- R8: A read strobe returns data on rdata, with rd_valid high, in the following cycle. Addresses 5 and 6 return the committed counter values. Address 255 returns the lock bits in bits [1:0] with zeros above. Every other address returns zero.
- R9: A write to any address other than 5, 6 or 255 has no effect and raises neither reject nor busy.
- R10: The two counters are independent: an operation on one never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Block address shared by reads and writes |
| wdata | input | 32 | Write data |
| pwr_fail | input | 1 | Supply-loss indication; aborts a programming sequence |
| busy | output | 1 | High while a programming sequence runs |
| reject | output | 1 | One-cycle pulse when a counter write is refused |
| rd_valid | output | 1 | High in the cycle that rdata carries a read result |
| rdata | output | 32 | Registered read data |

## Verification
The bench drives each input at a falling edge, so the design samples it at the next rising edge. It reads results at the falling edge that follows. Reject and read data are therefore checked exactly one cycle after their strobe. Busy is checked starting with that same sample, and the busy samples are counted until busy falls; the count must equal PROG_CYCLES. Power-fail is raised at every possible offset inside the sequence, from the first busy cycle to the last. Busy must be low one cycle later, and a read must then show the old value. After every operation the bench reads back both counters and compares them against a model it updates arithmetically. It also sweeps a read across all 256 addresses.

// File: rtl/mono_ctr_pkg.sv
package mono_ctr_pkg;

  // Outcome of a host write, as classified by the gate logic.
  typedef enum logic [1:0] {
    WR_IDLE   = 2'd0,
    WR_START  = 2'd1,
    WR_REFUSE = 2'd2,
    WR_LOCK   = 2'd3
  } wr_kind_e;

  // Minimum index width for a count of items (at least one bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mono_ctr_decode.sv
module mono_ctr_decode #(
  parameter int AW        = 8,
  parameter int N_CTR     = 2,
  parameter int CTR_BASE  = 5,
  parameter int LOCK_ADDR = 255,
  parameter int IDX_W     = 1
) (
  input  logic [AW-1:0]    addr,
  output logic [N_CTR-1:0] ctr_hit,
  output logic [IDX_W-1:0] ctr_idx,
  output logic             lock_hit
);

  // One comparator per counter slot; the slots occupy consecutive addresses.
  for (genvar k = 0; k < N_CTR; k++) begin : g_hit
    assign ctr_hit[k] = (addr == AW'(CTR_BASE + k));
  end

  // Encode the selected slot; at most one hit can be active.
  always_comb begin
    ctr_idx = '0;
    for (int k = 0; k < N_CTR; k++) begin
      if (ctr_hit[k]) ctr_idx = IDX_W'(k);
    end
  end

  assign lock_hit = (addr == AW'(LOCK_ADDR));

endmodule

// File: rtl/mono_ctr_gate.sv
module mono_ctr_gate
  import mono_ctr_pkg::*;
#(
  parameter int DW    = 32,
  parameter int N_CTR = 2,
  parameter int IDX_W = 1
) (
  input  logic              wr_en,
  input  logic              busy,
  input  logic [N_CTR-1:0]  ctr_hit,
  input  logic [IDX_W-1:0]  ctr_idx,
  input  logic              lock_hit,
  input  logic [DW-1:0]     wdata,
  input  logic [N_CTR*DW-1:0] ctr_flat,
  input  logic [N_CTR-1:0]  lock_q,
  output wr_kind_e          kind,
  output logic              start,
  output logic              refuse,
  output logic              lock_wr
);

  logic [DW-1:0] cur_val;
  logic          open_slot;
  logic          any_hit;
  logic          is_locked;
  logic          is_lower;

  assign cur_val   = ctr_flat[ctr_idx*DW +: DW];
  assign open_slot = wr_en && !busy;
  assign any_hit   = |ctr_hit;
  assign is_locked = lock_q[ctr_idx];
  // Strict magnitude compare: equal or larger values never pass, so zero is terminal.
  assign is_lower  = (wdata < cur_val);

  always_comb begin
    kind = WR_IDLE;
    if (open_slot) begin
      if (any_hit) begin
        kind = (!is_locked && is_lower) ? WR_START : WR_REFUSE;
      end else if (lock_hit) begin
        kind = WR_LOCK;
      end
    end
  end

  assign start   = (kind == WR_START);
  assign refuse  = (kind == WR_REFUSE);
  assign lock_wr = (kind == WR_LOCK);

endmodule

// File: rtl/mono_ctr_prog.sv
module mono_ctr_prog #(
  parameter int DW          = 32,
  parameter int IDX_W       = 1,
  parameter int PROG_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [DW-1:0]    start_val,
  input  logic             pwr_fail,
  output logic             busy,
  output logic             commit,
  output logic [IDX_W-1:0] commit_idx,
  output logic [DW-1:0]    commit_val
);

  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0]    cnt_q;
  logic [DW-1:0]    shadow_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic             last_cycle;

  assign last_cycle = (cnt_q == '0);
  // The commit fires on the edge that closes the final busy cycle, unless supply is failing.
  assign commit     = busy_q && !pwr_fail && last_cycle;
  assign commit_idx = idx_q;
  assign commit_val = shadow_q;
  assign busy       = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      shadow_q <= '0;
      idx_q    <= '0;
    end else if (busy_q) begin
      if (pwr_fail) begin
        busy_q <= 1'b0;          // tear: shadow is abandoned
        cnt_q  <= '0;
      end else if (last_cycle) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end else if (start) begin
      busy_q   <= 1'b1;
      cnt_q    <= CW'(PROG_CYCLES - 1);
      shadow_q <= start_val;
      idx_q    <= start_idx;
    end
  end

endmodule

// File: rtl/mono_ctr_store.sv
module mono_ctr_store #(
  parameter int DW       = 32,
  parameter int N_CTR    = 2,
  parameter int IDX_W    = 1,
  parameter logic [N_CTR*DW-1:0] INIT_VALS = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit,
  input  logic [IDX_W-1:0]   commit_idx,
  input  logic [DW-1:0]      commit_val,
  input  logic               lock_wr,
  input  logic [N_CTR-1:0]   lock_set,
  input  logic               rd_en,
  input  logic [N_CTR-1:0]   ctr_hit,
  input  logic [IDX_W-1:0]   ctr_idx,
  input  logic               lock_hit,
  output logic [N_CTR*DW-1:0] ctr_flat,
  output logic [N_CTR-1:0]   lock_q,
  output logic [DW-1:0]      rdata,
  output logic               rd_valid
);

  logic [DW-1:0]    ctr_q [N_CTR];
  logic [N_CTR-1:0] lock_r;

  // Counter cells: single write port driven only by the commit strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_CTR; k++) begin
        ctr_q[k] <= INIT_VALS[k*DW +: DW];
      end
    end else if (commit) begin
      ctr_q[commit_idx] <= commit_val;
    end
  end

  // Lock bits: set-only.
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_r <= '0;
    end else if (lock_wr) begin
      lock_r <= lock_r | lock_set;
    end
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (|ctr_hit) begin
          rdata <= ctr_q[ctr_idx];
        end else if (lock_hit) begin
          rdata <= {{(DW-N_CTR){1'b0}}, lock_r};
        end else begin
          rdata <= '0;
        end
      end
    end
  end

  for (genvar k = 0; k < N_CTR; k++) begin : g_flat
    assign ctr_flat[k*DW +: DW] = ctr_q[k];
  end

  assign lock_q = lock_r;

endmodule

// File: rtl/mono_ctr_bank.sv
module mono_ctr_bank
  import mono_ctr_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 32,
  parameter int N_CTR       = 2,
  parameter int CTR_BASE    = 5,
  parameter int LOCK_ADDR   = 255,
  parameter int PROG_CYCLES = 8,
  parameter logic [N_CTR*DW-1:0] INIT_VALS = {32'hFFFF_FFFF, 32'hFFFF_FFFE}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          pwr_fail,
  output logic          busy,
  output logic          reject,
  output logic          rd_valid,
  output logic [DW-1:0] rdata
);

  localparam int IDX_W = idx_width(N_CTR);

  logic [N_CTR-1:0]    ctr_hit;
  logic [IDX_W-1:0]    ctr_idx;
  logic                lock_hit;
  logic [N_CTR*DW-1:0] ctr_flat;
  logic [N_CTR-1:0]    lock_q;
  wr_kind_e            kind;
  logic                start;
  logic                refuse;
  logic                lock_wr;
  logic                commit;
  logic [IDX_W-1:0]    commit_idx;
  logic [DW-1:0]       commit_val;
  logic                busy_w;
  logic                reject_q;

  mono_ctr_decode #(
    .AW(AW), .N_CTR(N_CTR), .CTR_BASE(CTR_BASE),
    .LOCK_ADDR(LOCK_ADDR), .IDX_W(IDX_W)
  ) u_decode (
    .addr(addr), .ctr_hit(ctr_hit), .ctr_idx(ctr_idx), .lock_hit(lock_hit)
  );

  mono_ctr_gate #(
    .DW(DW), .N_CTR(N_CTR), .IDX_W(IDX_W)
  ) u_gate (
    .wr_en(wr_en), .busy(busy_w), .ctr_hit(ctr_hit), .ctr_idx(ctr_idx),
    .lock_hit(lock_hit), .wdata(wdata), .ctr_flat(ctr_flat), .lock_q(lock_q),
    .kind(kind), .start(start), .refuse(refuse), .lock_wr(lock_wr)
  );

  mono_ctr_prog #(
    .DW(DW), .IDX_W(IDX_W), .PROG_CYCLES(PROG_CYCLES)
  ) u_prog (
    .clk(clk), .rst(rst), .start(start), .start_idx(ctr_idx),
    .start_val(wdata), .pwr_fail(pwr_fail), .busy(busy_w),
    .commit(commit), .commit_idx(commit_idx), .commit_val(commit_val)
  );

  mono_ctr_store #(
    .DW(DW), .N_CTR(N_CTR), .IDX_W(IDX_W), .INIT_VALS(INIT_VALS)
  ) u_store (
    .clk(clk), .rst(rst), .commit(commit), .commit_idx(commit_idx),
    .commit_val(commit_val), .lock_wr(lock_wr), .lock_set(wdata[N_CTR-1:0]),
    .rd_en(rd_en), .ctr_hit(ctr_hit), .ctr_idx(ctr_idx), .lock_hit(lock_hit),
    .ctr_flat(ctr_flat), .lock_q(lock_q), .rdata(rdata), .rd_valid(rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) reject_q <= 1'b0;
    else     reject_q <= refuse;
  end

  assign busy   = busy_w;
  assign reject = reject_q;

endmodule

// File: rtl/mono_ctr_chk.sv
module mono_ctr_chk #(
  parameter int DW          = 32,
  parameter int N_CTR       = 2,
  parameter int PROG_CYCLES = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic                pwr_fail,
  input logic                busy,
  input logic                reject,
  input logic                rd_valid,
  input logic [N_CTR*DW-1:0] ctr_flat,
  input logic [N_CTR-1:0]    lock_q
);

  localparam int BW = $clog2(PROG_CYCLES + 1) + 1;
  logic [BW-1:0] blen;

  always_ff @(posedge clk) begin
    if (rst || !busy) blen <= '0;
    else              blen <= blen + 1'b1;
  end

  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (rst) busy |-> (blen < BW'(PROG_CYCLES))); // R3
  AST_TEAR_HOLD: assert property (@(posedge clk) disable iff (rst) (busy && pwr_fail) |=> (!busy && $stable(ctr_flat))); // R4
  AST_BUSY_NO_REJECT: assert property (@(posedge clk) disable iff (rst) (busy && wr_en) |=> !reject); // R5
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (rst) reject |-> !busy); // R2
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst) rd_en |=> rd_valid); // R8

  for (genvar k = 0; k < N_CTR; k++) begin : g_ctr
    AST_NEVER_RISES: assert property (@(posedge clk) disable iff (rst) (ctr_flat[k*DW +: DW] != $past(ctr_flat[k*DW +: DW])) |-> (ctr_flat[k*DW +: DW] < $past(ctr_flat[k*DW +: DW]))); // R2
    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (rst) (ctr_flat[k*DW +: DW] == '0) |=> (ctr_flat[k*DW +: DW] == '0)); // R6
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst) lock_q[k] |=> $stable(ctr_flat[k*DW +: DW])); // R7
    AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (rst) lock_q[k] |=> lock_q[k]); // R7
  end

endmodule

bind mono_ctr_bank mono_ctr_chk #(
  .DW(DW), .N_CTR(N_CTR), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .pwr_fail(pwr_fail),
  .busy(busy), .reject(reject), .rd_valid(rd_valid),
  .ctr_flat(ctr_flat), .lock_q(lock_q)
);

// File: tb/tb_mono_ctr_bank.sv
module tb_mono_ctr_bank;

  localparam int P = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        pwr_fail = 1'b0;
  logic        busy, reject, rd_valid;
  logic [31:0] rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] m [2];
  logic [1:0]  lk;

  always #5 clk = ~clk;

  mono_ctr_bank #(.PROG_CYCLES(P)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .pwr_fail(pwr_fail), .busy(busy), .reject(reject),
    .rd_valid(rd_valid), .rdata(rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic read_op(input string req, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, {31'b0, rd_valid}, 32'd1);
    d = rdata;
  endtask

  task automatic expect_ctrs(input string req);
    logic [31:0] d;
    read_op(req, 8'd5, d);
    check(req, d, m[0]);
    read_op(req, 8'd6, d);
    check(req, d, m[1]);
  endtask

  // Drive one write, return the reject sample and the number of busy cycles.
  task automatic write_op(input logic [7:0] a, input logic [31:0] d,
                          output logic rj, output int blen);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    rj = reject;
    blen = 0;
    while (busy && blen < 4 * P) begin
      blen++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input string req, input logic [7:0] a, input logic [31:0] d);
    logic rj;
    int   blen;
    logic exp_rj;
    int   exp_len;
    int   k;
    exp_rj = 1'b0;
    exp_len = 0;
    if (a == 8'd5 || a == 8'd6) begin
      k = (a == 8'd5) ? 0 : 1;
      if (!lk[k] && d < m[k]) begin
        exp_len = P;
        m[k] = d;
      end else begin
        exp_rj = 1'b1;
      end
    end else if (a == 8'd255) begin
      lk = lk | d[1:0];
    end
    write_op(a, d, rj, blen);
    check(req, {31'b0, rj}, {31'b0, exp_rj});
    check(req, blen, exp_len);
    expect_ctrs(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [31:0] e;
    int          n;
    m[0] = 32'hFFFF_FFFE;
    m[1] = 32'hFFFF_FFFF;
    lk = 2'b00;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    check("R1", {31'b0, busy}, 32'd0);
    check("R1", {31'b0, reject}, 32'd0);
    expect_ctrs("R1");
    read_op("R1", 8'd255, d);
    check("R1", d, 32'd0);

    // R8 sweep of all addresses
    for (int a = 0; a < 256; a++) begin
      read_op("R8", 8'(a), d);
      e = (a == 5) ? m[0] : (a == 6) ? m[1] : (a == 255) ? {30'b0, lk} : 32'd0;
      check("R8", d, e);
    end

    // R2 equal and larger values refused
    do_write("R2", 8'd5, 32'hFFFF_FFFF);
    do_write("R2", 8'd6, 32'hFFFF_FFFF);
    do_write("R2", 8'd5, 32'hFFFF_FFFE);

    // R3 accepted decrements of varying size; R10 independence via readback of both
    do_write("R3", 8'd5, 32'hFFFF_FFF0);
    for (int i = 1; i <= 6; i++) begin
      do_write("R3", 8'd6, m[1] - 32'(i * i * 37));
      do_write("R10", 8'd6, m[1] + 32'd1);
    end
    do_write("R3", 8'd5, m[0] - 32'd1);

    // R5 write during busy ignored
    @(negedge clk);
    wr_en = 1'b1; addr = 8'd5; wdata = m[0] - 32'd3;
    @(negedge clk);
    m[0] = m[0] - 32'd3;
    addr = 8'd6; wdata = 32'd0;
    @(negedge clk);
    addr = 8'd255; wdata = 32'd3;
    @(negedge clk);
    wr_en = 1'b0;
    check("R5", {31'b0, reject}, 32'd0);
    n = 3;
    while (busy && n < 4 * P) begin
      n++;
      @(negedge clk);
    end
    check("R5", n, P + 1);
    expect_ctrs("R5");
    read_op("R5", 8'd255, d);
    check("R5", d, 32'd0);

    // R4 power-fail at each offset of the sequence
    for (int j = 0; j < P; j++) begin
      @(negedge clk);
      wr_en = 1'b1; addr = 8'd6; wdata = m[1] - 32'(j + 1);
      @(negedge clk);
      wr_en = 1'b0;
      check("R4", {31'b0, busy}, 32'd1);
      repeat (j) @(negedge clk);
      pwr_fail = 1'b1;
      @(negedge clk);
      pwr_fail = 1'b0;
      check("R4", {31'b0, busy}, 32'd0);
      expect_ctrs("R4");
    end

    // R9 other addresses
    do_write("R9", 8'd7, 32'd0);
    do_write("R9", 8'd4, 32'd0);
    do_write("R9", 8'd0, 32'd1);
    do_write("R9", 8'd254, 32'd3);

    // R6 zero is terminal
    do_write("R6", 8'd5, 32'd0);
    do_write("R6", 8'd5, 32'd0);
    do_write("R6", 8'd5, 32'd1);
    do_write("R6", 8'd5, 32'hFFFF_FFFF);

    // R7 lock bits
    do_write("R7", 8'd255, 32'd2);
    read_op("R7", 8'd255, d);
    check("R7", d, 32'd2);
    do_write("R7", 8'd6, 32'd5);
    do_write("R7", 8'd6, m[1] - 32'd1);
    do_write("R7", 8'd255, 32'd0);
    read_op("R7", 8'd255, d);
    check("R7", d, 32'd2);
    do_write("R7", 8'd255, 32'd1);
    read_op("R7", 8'd255, d);
    check("R7", d, 32'd3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule